// File: doc/BRIEF.md
# Trigger Final-OR Decision Stage

This block reduces a wide vector of per-algorithm result bits to a single accept decision once per bunch-crossing clock. Each algorithm bit has its own programmable prescaler and its own saturating occurrence counter. An enable mask chooses which prescaled bits enter a wide OR. A veto mask chooses bits whose raw assertion forces the decision low. The accept output is registered and follows the algorithm-bit input by a fixed two cycles.

Software reaches the masks, the prescale factors and the counters through a flat register port. A region select picks the register group. An index picks the word or the algorithm within that group. Writes take effect at a clock edge. Reads return data combinationally.

Top module: `trig_final_or`

## Requirements
- R1: After reset, accept is 0, both masks read 0, every prescale factor reads 1 and every counter reads 0.
- R2: The algorithm bits are sampled at one edge, and the accept for them is registered at the next edge. This gives a fixed latency of 2 clock cycles from input to accept. Accept is a single-cycle pulse for an isolated input.
- R3: A bit contributes to accept only when its enable-mask bit is 1. Region select 1 addresses the enable mask. Index w addresses the 32-bit word w, and bit b of the mask is bit b%32 of word b/32.
- R4: With prescale factor N ≥ 1, a bit passes its Nth, 2Nth, 3Nth … assertion. With N = 0 it never passes. Writing a factor restarts the count of that bit. Region select 3 addresses the factors, with index i for algorithm i.
- R5: A raw (unprescaled) assertion of any bit set in the veto mask forces accept to 0 for that crossing. This holds even when the bit's own prescaler blocks it. Region select 2 addresses the veto mask, with the same word layout as R3.
- R6: Each algorithm's counter counts raw assertions before prescaling. Region select 4 reads it, with index i for algorithm i.
- R7: A counter stops at its all-ones value and does not wrap.
- R8: Writing 1 to bit 0 at region select 0 clears every counter. If a count and a clear fall in the same cycle, the clear wins and the counter reads 0.
- R9: A mask write in the same cycle that a decision is formed does not affect that decision. The decision uses only the settings held before that edge, and the new settings apply from the next decision onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Active-low synchronous reset |
| algoIn | input | NUM_ALGO | Per-algorithm result bits |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Region select: 0 control, 1 enable, 2 veto, 3 prescale, 4 counter |
| regIdx | input | IDX_W | Word or algorithm index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regSel/regIdx |
| accept | output | 1 | Registered final decision |

## Verification
Two of the block's functions can fall in the same cycle. The first is a counter clear arriving while that algorithm's bit is counted. The bench drives the bit and the clear write together, then reads the counter back and expects 0. The second is an enable-mask write landing on the edge where a decision is formed. The bench places the write one cycle after the input, so that it meets the decision edge. The old mask must still produce the accept, and a later identical input must then be blocked.

// File: rtl/tfo_pkg.sv
package tfo_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_VETO   = 3'd2,
    SEL_SCALE  = 3'd3,
    SEL_COUNT  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic clrCnt;
    logic enWr;
    logic vetoWr;
    logic psWr;
  } cfgStrobe_t;
endpackage

// File: rtl/tfo_algo_slice.sv
module tfo_algo_slice #(
  parameter int PS_W  = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             psWr,
  input  logic [PS_W-1:0]  psData,
  input  logic             clrCnt,
  output logic             passOut,
  output logic [PS_W-1:0]  psOut,
  output logic [CNT_W-1:0] cntOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PS_W-1:0] psReg;
  logic [PS_W-1:0] phase;
  logic            hit;

  assign hit     = (psReg != '0) && (phase == psReg - 1'b1);
  assign passOut = bitIn && hit;
  assign psOut   = psReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psReg <= PS_W'(1);
      phase <= '0;
    end else if (psWr) begin
      psReg <= psData;
      phase <= '0;
    end else if (bitIn && psReg != '0) begin
      phase <= hit ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrCnt) cntOut <= '0;
    else if (bitIn && cntOut != CNT_MAX) cntOut <= cntOut + 1'b1;
  end
endmodule

// File: rtl/tfo_datapath.sv
module tfo_datapath
  import tfo_pkg::*;
#(
  parameter int NUM_ALGO = 128,
  parameter int PS_W     = 8,
  parameter int CNT_W    = 32,
  parameter int IDX_W    = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_ALGO-1:0]       algoIn,
  input  cfgStrobe_t                strobe,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [31:0]               wrData,
  output logic                      accept,
  output logic [NUM_ALGO-1:0]       enMask,
  output logic [NUM_ALGO-1:0]       vetoMask,
  output logic [NUM_ALGO*PS_W-1:0]  psFlat,
  output logic [NUM_ALGO*CNT_W-1:0] cntFlat
);
  logic [NUM_ALGO-1:0] inReg;
  logic [NUM_ALGO-1:0] passVec;

  always_ff @(posedge clk) begin
    if (!rstN) inReg <= '0;
    else       inReg <= algoIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask   <= '0;
      vetoMask <= '0;
    end else begin
      for (int b = 0; b < NUM_ALGO; b++) begin
        if (b / 32 == int'(wrIdx)) begin
          if (strobe.enWr)   enMask[b]   <= wrData[b % 32];
          if (strobe.vetoWr) vetoMask[b] <= wrData[b % 32];
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_ALGO; i++) begin : g_slice
    tfo_algo_slice #(.PS_W(PS_W), .CNT_W(CNT_W)) slice_i (
      .clk     (clk),
      .rstN    (rstN),
      .bitIn   (inReg[i]),
      .psWr    (strobe.psWr && (int'(wrIdx) == i)),
      .psData  (wrData[PS_W-1:0]),
      .clrCnt  (strobe.clrCnt),
      .passOut (passVec[i]),
      .psOut   (psFlat[i*PS_W +: PS_W]),
      .cntOut  (cntFlat[i*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) accept <= 1'b0;
    else       accept <= (|(passVec & enMask)) && !(|(inReg & vetoMask));
  end
endmodule

// File: rtl/tfo_ctrl.sv
module tfo_ctrl
  import tfo_pkg::*;
#(
  parameter int NUM_ALGO = 128,
  parameter int PS_W     = 8,
  parameter int CNT_W    = 32,
  parameter int IDX_W    = 7
) (
  input  logic                      regWrEn,
  input  logic [2:0]                regSel,
  input  logic [IDX_W-1:0]          regIdx,
  input  logic                      clrBit,
  input  logic [NUM_ALGO-1:0]       enMask,
  input  logic [NUM_ALGO-1:0]       vetoMask,
  input  logic [NUM_ALGO*PS_W-1:0]  psFlat,
  input  logic [NUM_ALGO*CNT_W-1:0] cntFlat,
  output cfgStrobe_t                strobe,
  output logic [31:0]               regRdData
);
  regSel_e sel;
  assign sel = regSel_e'(regSel);

  always_comb begin
    strobe.clrCnt = regWrEn && sel == SEL_CTRL && clrBit;
    strobe.enWr   = regWrEn && sel == SEL_ENABLE;
    strobe.vetoWr = regWrEn && sel == SEL_VETO;
    strobe.psWr   = regWrEn && sel == SEL_SCALE;
  end

  always_comb begin
    regRdData = '0;
    case (sel)
      SEL_ENABLE, SEL_VETO: begin
        for (int b = 0; b < NUM_ALGO; b++)
          if (b / 32 == int'(regIdx))
            regRdData[b % 32] = (sel == SEL_ENABLE) ? enMask[b] : vetoMask[b];
      end
      SEL_SCALE:
        if (int'(regIdx) < NUM_ALGO)
          regRdData[PS_W-1:0] = psFlat[int'(regIdx)*PS_W +: PS_W];
      SEL_COUNT:
        if (int'(regIdx) < NUM_ALGO)
          regRdData[CNT_W-1:0] = cntFlat[int'(regIdx)*CNT_W +: CNT_W];
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/trig_final_or.sv
module trig_final_or
  import tfo_pkg::*;
#(
  parameter int NUM_ALGO = 128,
  parameter int PS_W     = 8,
  parameter int CNT_W    = 32,
  localparam int IDX_W   = (NUM_ALGO > 1) ? $clog2(NUM_ALGO) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ALGO-1:0] algoIn,
  input  logic                regWrEn,
  input  logic [2:0]          regSel,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic                accept
);
  cfgStrobe_t                strobe;
  logic [NUM_ALGO-1:0]       enMask;
  logic [NUM_ALGO-1:0]       vetoMask;
  logic [NUM_ALGO*PS_W-1:0]  psFlat;
  logic [NUM_ALGO*CNT_W-1:0] cntFlat;

  tfo_ctrl #(.NUM_ALGO(NUM_ALGO), .PS_W(PS_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regIdx    (regIdx),
    .clrBit    (regWrData[0]),
    .enMask    (enMask),
    .vetoMask  (vetoMask),
    .psFlat    (psFlat),
    .cntFlat   (cntFlat),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  tfo_datapath #(.NUM_ALGO(NUM_ALGO), .PS_W(PS_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .algoIn   (algoIn),
    .strobe   (strobe),
    .wrIdx    (regIdx),
    .wrData   (regWrData),
    .accept   (accept),
    .enMask   (enMask),
    .vetoMask (vetoMask),
    .psFlat   (psFlat),
    .cntFlat  (cntFlat)
  );
endmodule

// File: rtl/tfo_checker.sv
module tfo_checker #(
  parameter int NUM_ALGO = 128,
  parameter int CNT_W    = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_ALGO-1:0]       algoIn,
  input logic                      regWrEn,
  input logic [2:0]                regSel,
  input logic [31:0]               regWrData,
  input logic                      accept,
  input logic [NUM_ALGO-1:0]       enMask,
  input logic [NUM_ALGO-1:0]       vetoMask,
  input logic [NUM_ALGO*CNT_W-1:0] cntFlat
);
  logic clrReq;
  logic [CNT_W-1:0] cnt0;
  assign clrReq = regWrEn && regSel == 3'd0 && regWrData[0];
  assign cnt0   = cntFlat[CNT_W-1:0];

  AST_VETO_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(algoIn, 2) & $past(vetoMask))) |-> !accept); // R5

  AST_NO_ENABLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enMask) == '0) |-> !accept); // R3

  AST_ACCEPT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (|($past(algoIn, 2) & $past(enMask)))); // R2

  AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrReq) |-> cnt0 >= $past(cnt0)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, cnt0} <= {1'b0, $past(cnt0)} + 1'b1); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(clrReq) |-> cnt0 == '0); // R8
endmodule

bind trig_final_or tfo_checker #(.NUM_ALGO(NUM_ALGO), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .algoIn    (algoIn),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .accept    (accept),
  .enMask    (enMask),
  .vetoMask  (vetoMask),
  .cntFlat   (cntFlat)
);

// File: tb/trig_final_or_tb_top.sv
module trig_final_or_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int PW = 4;
  localparam int CW = 4;
  localparam int IW = 3;

  logic          clk = 0;
  logic          rstN = 0;
  logic [NA-1:0] algoIn = '0;
  logic          regWrEn = 0;
  logic [2:0]    regSel = '0;
  logic [IW-1:0] regIdx = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          accept;

  int checks = 0;
  int errors = 0;
  int accCount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_final_or #(.NUM_ALGO(NA), .PS_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .algoIn(algoIn), .regWrEn(regWrEn), .regSel(regSel),
    .regIdx(regIdx), .regWrData(regWrData), .regRdData(regRdData), .accept(accept)
  );

  always @(negedge clk) if (rstN && accept) accCount++;

  task automatic check(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int sel, input int idx, input int data);
    @(negedge clk);
    regWrEn = 1; regSel = 3'(sel); regIdx = IW'(idx); regWrData = 32'(data);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(input int sel, input int idx, output int data);
    @(negedge clk);
    regSel = 3'(sel); regIdx = IW'(idx);
    #1 data = int'(regRdData);
  endtask

  task automatic pulse(input int bits, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      algoIn = NA'(bits);
    end
    @(negedge clk);
    algoIn = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(accept, 0, "R1 accept");
    rdReg(1, 0, v); check(v, 0, "R1 enable mask");
    rdReg(2, 0, v); check(v, 0, "R1 veto mask");
    for (int i = 0; i < NA; i++) begin
      rdReg(3, i, v); check(v, 1, "R1 prescale");
      rdReg(4, i, v); check(v, 0, "R1 counter");
    end

    // R2 latency and pulse width
    wrReg(1, 0, 1);
    @(negedge clk); algoIn = 1;
    @(negedge clk); algoIn = 0; check(accept, 0, "R2 cycle1");
    @(negedge clk); check(accept, 1, "R2 cycle2");
    @(negedge clk); check(accept, 0, "R2 cycle3");

    // R3 mask sweep
    for (int b = 0; b < NA; b++) begin
      wrReg(1, 0, 1 << b);
      for (int j = 0; j < NA; j++) begin
        @(negedge clk); algoIn = NA'(1 << j);
        @(negedge clk); algoIn = 0;
        @(negedge clk); check(accept, (b == j) ? 1 : 0, "R3 mask");
      end
    end

    // R4 prescale sweep on bit 0
    wrReg(1, 0, 1);
    for (int n = 0; n <= 6; n++) begin
      wrReg(3, 0, n);
      idle(3);
      accCount = 0;
      pulse(1, 12);
      idle(3);
      check(accCount, (n == 0) ? 0 : 12 / n, "R4 prescale");
    end
    // R4 restart on write: 2 of 3 counted, rewrite, 2 more -> no pass
    wrReg(3, 0, 3);
    accCount = 0;
    pulse(1, 2);
    wrReg(3, 0, 3);
    pulse(1, 2);
    idle(3);
    check(accCount, 0, "R4 restart");

    // R5 veto by raw bit 3 with its prescale 0
    wrReg(3, 0, 1);
    wrReg(3, 3, 0);
    wrReg(2, 0, 8);
    idle(3); accCount = 0;
    pulse(9, 1); idle(3);
    check(accCount, 0, "R5 vetoed");
    accCount = 0;
    pulse(1, 1); idle(3);
    check(accCount, 1, "R5 no veto");
    wrReg(2, 0, 0);

    // R6 raw counting despite prescale 0
    wrReg(0, 0, 1);
    wrReg(3, 2, 0);
    pulse(4, 5); idle(3);
    rdReg(4, 2, v); check(v, 5, "R6 count");
    rdReg(4, 1, v); check(v, 0, "R6 other count");

    // R7 saturation
    pulse(4, 20); idle(3);
    rdReg(4, 2, v); check(v, 15, "R7 saturate");

    // R8 clear in same cycle as count (bit reaches counter one edge after drive)
    @(negedge clk); algoIn = 4;
    @(negedge clk); algoIn = 0; regWrEn = 1; regSel = 0; regWrData = 1;
    @(negedge clk); regWrEn = 0;
    idle(2);
    rdReg(4, 2, v); check(v, 0, "R8 clear wins");

    // R9 enable write on the decision edge
    wrReg(1, 0, 1);
    idle(2); accCount = 0;
    @(negedge clk); algoIn = 1;
    @(negedge clk); algoIn = 0; regWrEn = 1; regSel = 1; regIdx = 0; regWrData = 0;
    @(negedge clk); regWrEn = 0; check(accept, 1, "R9 old mask used");
    pulse(1, 1); idle(3);
    check(accCount, 1, "R9 new mask applied");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule